// File: doc/BRIEF.md
# Page Permission and Reference/Change Unit

This unit sits after a page-table walker and judges one leaf entry at a time. Each request carries:

- the 64-bit leaf entry and the physical address it was read from;
- the access kind (load, store or instruction fetch);
- a problem-state (user) flag;
- a partition-scope flag;
- a three-bit authority mask.

From these it derives the read/write/execute rights to grant and decides whether the access faults. A fault comes with a cause code.

When the access succeeds, the unit marks the entry as referenced, and also as changed when the access is a store. If that makes the entry differ from the copy it was given, the unit sends exactly one write request to memory before it answers. When the access is not a store, the unit removes the write right from the rights it returns. This forces a later store to come back through the unit so that the changed mark gets set.

Requests use a valid/ready pair, responses use a valid/ready pair, and the memory write port is a plain valid/ready write channel. Only one request is in flight at a time.

Top module: `pte_perm_rc_unit`

## Requirements
- R1: A fetch from an entry whose attribute field (bits 5:4) equals 2'b10 (non-idempotent I/O) always faults with cause 32'h1000_0000, whatever rights the entry holds. Access kinds are encoded on `req_access` as load 2'd0, store 2'd1, fetch 2'd2.
- R2: A check that is not partition-scoped (`req_partition`=0) on a privileged-only entry (bit 3 set) from user state grants no rights at all.
- R3: The entry's own rights are read at bit 2 (read), bit 1 (write) and bit 0 (execute). These rights are used unmodified when the access is from user state, when the entry is privileged-only, or when the check is partition-scoped. In every other case they are ANDed with `req_amr`, which uses the same {read, write, execute} order in bits 2:0.
- R4: A load needs read, a store needs write and a fetch needs execute. If the needed right is missing, the access faults. The cause is 32'h1000_0000 for a fetch and 32'h0800_0000 for a load. A store reports 32'h0800_0000 with 32'h0200_0000 ORed in. On any fault `rsp_perm` is 3'b000.
- R5: On success the updated entry has bit 8 (referenced) set. For a store it also has bit 7 (changed) set. No other bit of the entry is altered.
- R6: On a successful non-store access, `rsp_perm[1]` (write) is 0. On a successful store, `rsp_perm` carries the granted rights unchanged.
- R7: A write request goes out only when the updated entry differs from the original, and a faulting access never writes. The write address equals `req_pte_addr` and the write data is the updated entry.
- R8: The write handshake completes before `rsp_valid` rises. While `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R9: After reset `req_ready`=1, `rsp_valid`=0 and `wr_valid`=0. `req_ready` is low while a request is being processed. A response and its fields hold until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and taking a request |
| req_pte | input | PTE_W | Leaf entry under check |
| req_pte_addr | input | ADDR_W | Physical address of the entry |
| req_access | input | 2 | 0 load, 1 store, 2 fetch |
| req_user | input | 1 | Access from problem (user) state |
| req_partition | input | 1 | Partition-scoped check |
| req_amr | input | 3 | Authority mask {read, write, execute} |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 32 | Fault cause code, 0 on success |
| rsp_perm | output | 3 | Granted rights {read, write, execute} |
| wr_valid | output | 1 | Entry write-back request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Write-back address |
| wr_data | output | PTE_W | Updated entry |

## Verification
The hardest situation to reach from the ports is a write-back that memory keeps stalling while a finished response waits behind it. Reaching it needs a successful access whose entry actually changes, combined with `wr_ready` held low. The bench sets this up by issuing a load to a fresh entry with the write port held off for several cycles. It then confirms that no response appears and that the write fields stay frozen. After that it holds `rsp_ready` low to confirm the response holds too. Entries whose marks are already set check the opposite case, where no write is issued.

// File: rtl/pte_perm_pkg.sv
package pte_perm_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  // entry field positions
  localparam int X_BIT    = 0;
  localparam int W_BIT    = 1;
  localparam int R_BIT    = 2;
  localparam int PRIV_BIT = 3;
  localparam int ATT_LO   = 4;
  localparam int ATT_HI   = 5;
  localparam int CHG_BIT  = 7;
  localparam int REF_BIT  = 8;
  localparam logic [1:0] ATT_NIO = 2'b10;

  // rights vector: [2]=read [1]=write [0]=execute
  localparam int NPERM  = 3;
  localparam int PERM_R = 2;
  localparam int PERM_W = 1;
  localparam int PERM_X = 0;
  typedef logic [NPERM-1:0] perm_t;

  localparam int CAUSE_W = 32;
  localparam logic [CAUSE_W-1:0] CAUSE_NOEXEC = 32'h1000_0000;
  localparam logic [CAUSE_W-1:0] CAUSE_PROT   = 32'h0800_0000;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE  = 32'h0200_0000;

  function automatic perm_t need_perm(acc_e a);
    perm_t p;
    p = '0;
    case (a)
      ACC_LOAD:  p[PERM_R] = 1'b1;
      ACC_STORE: p[PERM_W] = 1'b1;
      default:   p[PERM_X] = 1'b1;
    endcase
    return p;
  endfunction

  function automatic perm_t entry_auth(logic [15:0] low);
    perm_t p;
    p[PERM_R] = low[R_BIT];
    p[PERM_W] = low[W_BIT];
    p[PERM_X] = low[X_BIT];
    return p;
  endfunction

  function automatic logic [CAUSE_W-1:0] fault_code(acc_e a);
    case (a)
      ACC_FETCH: return CAUSE_NOEXEC;
      ACC_STORE: return CAUSE_PROT | CAUSE_STORE;
      default:   return CAUSE_PROT;
    endcase
  endfunction

  function automatic logic [15:0] rc_marks(acc_e a);
    logic [15:0] m;
    m = '0;
    m[REF_BIT] = 1'b1;
    if (a == ACC_STORE) m[CHG_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
  import pte_perm_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0]   pte,
  input  acc_e               acc,
  input  logic               user,
  input  logic               partition,
  input  perm_t              amr,
  output perm_t              granted,
  output logic               io_fetch,
  output logic               priv_block,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  logic [15:0] low;
  logic        priv_page;
  logic        bypass_mask;
  perm_t       auth;
  perm_t       need;

  assign low         = pte[15:0];
  assign priv_page   = low[PRIV_BIT];
  assign auth        = entry_auth(low);
  assign need        = need_perm(acc);
  assign io_fetch    = (acc == ACC_FETCH) && (low[ATT_HI:ATT_LO] == ATT_NIO);
  assign priv_block  = !partition && priv_page && user;
  assign bypass_mask = user || priv_page || partition;

  for (genvar i = 0; i < NPERM; i++) begin : g_right
    assign granted[i] = !priv_block && auth[i] && (bypass_mask || amr[i]);
  end

  assign fault = io_fetch || (|(need & ~granted));
  assign cause = fault ? fault_code(acc) : '0;
endmodule

// File: rtl/pte_rc_update.sv
module pte_rc_update
  import pte_perm_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte,
  input  acc_e             acc,
  input  perm_t            granted,
  output logic [PTE_W-1:0] new_pte,
  output logic             dirty,
  output perm_t            ret_perm
);
  localparam int PAD_W = PTE_W - 16;

  logic [PTE_W-1:0] marks;

  assign marks    = {{PAD_W{1'b0}}, rc_marks(acc)};
  assign new_pte  = pte | marks;
  assign dirty    = (new_pte != pte);
  assign ret_perm = (acc == ACC_STORE) ? granted
                                       : (granted & ~perm_t'(1 << PERM_W));
endmodule

// File: rtl/pte_perm_ctrl.sv
module pte_perm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic fault,
  input  logic dirty,
  input  logic wr_ready,
  input  logic rsp_ready,
  output logic req_ready,
  output logic wr_valid,
  output logic rsp_valid,
  output logic accept
);
  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_RESP} st_e;
  st_e st_q, st_d;

  assign req_ready = (st_q == S_IDLE);
  assign wr_valid  = (st_q == S_WRITE);
  assign rsp_valid = (st_q == S_RESP);
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (accept) st_d = (!fault && dirty) ? S_WRITE : S_RESP;
      S_WRITE: if (wr_ready) st_d = S_RESP;
      S_RESP:  if (rsp_ready) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/pte_perm_rc_unit.sv
module pte_perm_rc_unit
  import pte_perm_pkg::*;
#(
  parameter int PTE_W  = 64,
  parameter int ADDR_W = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PTE_W-1:0]  req_pte,
  input  logic [ADDR_W-1:0] req_pte_addr,
  input  logic [1:0]        req_access,
  input  logic              req_user,
  input  logic              req_partition,
  input  logic [2:0]        req_amr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [31:0]       rsp_cause,
  output logic [2:0]        rsp_perm,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PTE_W-1:0]  wr_data
);
  acc_e               acc_in;
  perm_t              granted_w;
  perm_t              ret_perm_w;
  logic               io_fetch_w;
  logic               priv_block_w;
  logic               fault_w;
  logic               dirty_w;
  logic               accept;
  logic [CAUSE_W-1:0] cause_w;
  logic [PTE_W-1:0]   new_pte_w;

  acc_e               acc_q;
  logic               fault_q;
  logic [CAUSE_W-1:0] cause_q;
  perm_t              perm_q;
  logic [PTE_W-1:0]   data_q;
  logic [ADDR_W-1:0]  addr_q;

  assign acc_in = acc_e'(req_access);

  pte_perm_eval #(.PTE_W(PTE_W)) eval_i (
    .pte(req_pte), .acc(acc_in), .user(req_user), .partition(req_partition),
    .amr(req_amr), .granted(granted_w), .io_fetch(io_fetch_w),
    .priv_block(priv_block_w), .fault(fault_w), .cause(cause_w)
  );

  pte_rc_update #(.PTE_W(PTE_W)) rc_i (
    .pte(req_pte), .acc(acc_in), .granted(granted_w),
    .new_pte(new_pte_w), .dirty(dirty_w), .ret_perm(ret_perm_w)
  );

  pte_perm_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fault(fault_w),
    .dirty(dirty_w), .wr_ready(wr_ready), .rsp_ready(rsp_ready),
    .req_ready(req_ready), .wr_valid(wr_valid), .rsp_valid(rsp_valid),
    .accept(accept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= ACC_LOAD;
      fault_q <= 1'b0;
      cause_q <= '0;
      perm_q  <= '0;
      data_q  <= '0;
      addr_q  <= '0;
    end else if (accept) begin
      acc_q   <= acc_in;
      fault_q <= fault_w;
      cause_q <= cause_w;
      perm_q  <= fault_w ? perm_t'(0) : ret_perm_w;
      data_q  <= new_pte_w;
      addr_q  <= req_pte_addr;
    end
  end

  assign rsp_fault = fault_q;
  assign rsp_cause = cause_q;
  assign rsp_perm  = perm_q;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
endmodule

// File: rtl/pte_perm_rc_checker.sv
module pte_perm_rc_checker
  import pte_perm_pkg::*;
#(
  parameter int PTE_W  = 64,
  parameter int ADDR_W = 56
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [PTE_W-1:0]  req_pte,
  input logic [1:0]        req_access,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_fault,
  input logic [31:0]       rsp_cause,
  input logic [2:0]        rsp_perm,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [PTE_W-1:0]  wr_data,
  input logic [1:0]        acc_q
);
  assert_io_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_access == 2'd2 && req_pte[5:4] == 2'b10)
    |=> (rsp_valid && rsp_fault && rsp_cause == 32'h1000_0000));

  assert_fault_no_rights_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_perm == 3'b000));

  assert_read_only_nonstore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault && acc_q != 2'd1) |-> !rsp_perm[1]);

  assert_ref_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[8]);

  assert_write_before_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rsp_valid);

  assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cause) && $stable(rsp_perm)));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || rsp_valid) |-> !req_ready);
endmodule

bind pte_perm_rc_unit pte_perm_rc_checker #(.PTE_W(PTE_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_pte(req_pte), .req_access(req_access), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
  .rsp_perm(rsp_perm), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .acc_q(acc_q)
);

// File: tb/pte_perm_rc_unit_tb_top.sv
module pte_perm_rc_unit_tb_top;
  localparam int PTE_W  = 64;
  localparam int ADDR_W = 56;
  localparam int NVEC   = 13;

  typedef struct packed {
    logic [63:0] pte;
    logic [1:0]  acc;
    logic        user;
    logic        part;
    logic [2:0]  amr;
    logic        e_fault;
    logic [31:0] e_cause;
    logic [2:0]  e_perm;
    logic        e_wr;
    logic [63:0] e_data;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    // R5/R6/R7 load on fresh entry: ref mark, write right dropped
    '{64'h007, 2'd0, 1'b0, 1'b0, 3'b111, 1'b0, 32'h0, 3'b101, 1'b1, 64'h107},
    // R7 store, marks already set: no write
    '{64'h187, 2'd1, 1'b0, 1'b0, 3'b111, 1'b0, 32'h0, 3'b111, 1'b0, 64'h0},
    // R3/R4 mask removes write: store fault with store bit
    '{64'h007, 2'd1, 1'b0, 1'b0, 3'b101, 1'b1, 32'h0A00_0000, 3'b000, 1'b0, 64'h0},
    // R3 user state ignores mask; R5 store sets both marks
    '{64'h007, 2'd1, 1'b1, 1'b0, 3'b101, 1'b0, 32'h0, 3'b111, 1'b1, 64'h187},
    // R2 privileged page from user, process scope: no rights
    '{64'h00F, 2'd0, 1'b1, 1'b0, 3'b111, 1'b1, 32'h0800_0000, 3'b000, 1'b0, 64'h0},
    // R2/R3 same but partition-scoped: entry rights apply
    '{64'h00F, 2'd0, 1'b1, 1'b1, 3'b000, 1'b0, 32'h0, 3'b101, 1'b1, 64'h10F},
    // R1 fetch from I/O page with all rights
    '{64'h027, 2'd2, 1'b0, 1'b0, 3'b111, 1'b1, 32'h1000_0000, 3'b000, 1'b0, 64'h0},
    // R1 load from I/O page is allowed
    '{64'h025, 2'd0, 1'b0, 1'b0, 3'b111, 1'b0, 32'h0, 3'b101, 1'b1, 64'h125},
    // R4 fetch without execute
    '{64'h006, 2'd2, 1'b0, 1'b0, 3'b111, 1'b1, 32'h1000_0000, 3'b000, 1'b0, 64'h0},
    // R3 privileged page ignores empty mask; R7 no change on fetch
    '{64'h109, 2'd2, 1'b0, 1'b0, 3'b000, 1'b0, 32'h0, 3'b001, 1'b0, 64'h0},
    // R3/R4 mask removes execute
    '{64'h007, 2'd2, 1'b0, 1'b0, 3'b110, 1'b1, 32'h1000_0000, 3'b000, 1'b0, 64'h0},
    // R3/R4 mask removes read
    '{64'h107, 2'd0, 1'b0, 1'b0, 3'b011, 1'b1, 32'h0800_0000, 3'b000, 1'b0, 64'h0},
    // R5 upper bits pass through on store
    '{64'hDEAD_0000_0000_0003, 2'd1, 1'b1, 1'b0, 3'b000, 1'b0, 32'h0, 3'b011, 1'b1,
      64'hDEAD_0000_0000_0183}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [PTE_W-1:0]  req_pte = '0;
  logic [ADDR_W-1:0] req_pte_addr = '0;
  logic [1:0]        req_access = '0;
  logic              req_user = 1'b0;
  logic              req_partition = 1'b0;
  logic [2:0]        req_amr = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic              rsp_fault;
  logic [31:0]       rsp_cause;
  logic [2:0]        rsp_perm;
  logic              wr_valid;
  logic              wr_ready = 1'b1;
  logic [ADDR_W-1:0] wr_addr;
  logic [PTE_W-1:0]  wr_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pte_perm_rc_unit #(.PTE_W(PTE_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pte(req_pte), .req_pte_addr(req_pte_addr), .req_access(req_access),
    .req_user(req_user), .req_partition(req_partition), .req_amr(req_amr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_perm(rsp_perm), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic send(input vec_t v, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_pte = v.pte; req_pte_addr = a; req_access = v.acc;
    req_user = v.user; req_partition = v.part; req_amr = v.amr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input logic [ADDR_W-1:0] a);
    bit              seen_wr;
    logic [63:0]     got_data;
    logic [ADDR_W-1:0] got_addr;
    seen_wr = 0; got_data = '0; got_addr = '0;
    send(v, a);
    for (int c = 0; c < 20; c++) begin
      if (wr_valid) begin seen_wr = 1; got_data = wr_data; got_addr = wr_addr; end
      if (rsp_valid) break;
      @(negedge clk);
    end
    check(rsp_valid, "R9 response present", 64'(rsp_valid), 64'h1);
    check(rsp_fault == v.e_fault, "R4 fault flag", 64'(rsp_fault), 64'(v.e_fault));
    check(rsp_cause == v.e_cause, "R1/R4 cause", 64'(rsp_cause), 64'(v.e_cause));
    check(rsp_perm == v.e_perm, "R2/R3/R6 rights", 64'(rsp_perm), 64'(v.e_perm));
    check(seen_wr == v.e_wr, "R7 write issued", 64'(seen_wr), 64'(v.e_wr));
    if (v.e_wr) begin
      check(got_data == v.e_data, "R5 written entry", got_data, v.e_data);
      check(got_addr == a, "R7 write address", 64'(got_addr), 64'(a));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9 reset req_ready", 64'(req_ready), 64'h1);
    check(rsp_valid == 1'b0, "R9 reset rsp_valid", 64'(rsp_valid), 64'h0);
    check(wr_valid == 1'b0, "R9 reset wr_valid", 64'(wr_valid), 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      run_vec(VEC[i], ADDR_W'(56'h1000 + i * 8));
    end

    // R8: write port stalled, response must wait, write fields frozen
    wr_ready = 1'b0;
    send(VEC[0], 56'h00AB_CDE8);
    for (int c = 0; c < 4; c++) begin
      check(wr_valid == 1'b1, "R8 write held", 64'(wr_valid), 64'h1);
      check(rsp_valid == 1'b0, "R8 no early response", 64'(rsp_valid), 64'h0);
      check(wr_data == 64'h107, "R8 write data stable", wr_data, 64'h107);
      check(wr_addr == 56'h00AB_CDE8, "R8 write addr stable", 64'(wr_addr), 64'hABCDE8);
      check(req_ready == 1'b0, "R9 busy during write", 64'(req_ready), 64'h0);
      @(negedge clk);
    end
    wr_ready = 1'b1;
    rsp_ready = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b1, "R8 response after write", 64'(rsp_valid), 64'h1);
    check(wr_valid == 1'b0, "R8 write done", 64'(wr_valid), 64'h0);
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R9 response held", 64'(rsp_valid), 64'h1);
    check(rsp_perm == 3'b101, "R9 rights held", 64'(rsp_perm), 64'h5);
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 back to idle",
          64'({rsp_valid, req_ready}), 64'h1);

    // R1: I/O fetch after stall test, fault without write
    run_vec(VEC[6], 56'h2000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule